// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block runs the stack side of an 8-bit processor. It holds the stack pointer and drives a byte-wide memory port through the multi-cycle push and pull sequences behind a subroutine call, a subroutine return, a software break, a return from interrupt, and single-byte saves and restores of the accumulator and the flag register. The processor core gives one start strobe per operation, together with the current program counter, flags, accumulator and call target. It then waits for a one-cycle `done` pulse, after which the new program counter, flags and accumulator can be read from the outputs.

The stack sits in a fixed page: every stack byte is at address `{STACK_PAGE, sp}`, with `STACK_PAGE = 8'h01`. The pointer is 8 bits wide and wraps inside that page. Memory reads are combinational, so read data must be valid in the same cycle that the address is driven. Writes take effect at the clock edge.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is 8'hFF, `done` is 0 and `busy` is 0.
- R2: Every stack write and stack read uses address `{8'h01, byte}`, where byte is the stack pointer for a write and the stack pointer plus one for a read.
- R3: A push writes at the current `sp` and then decrements it. A pull increments `sp` and then reads. Both wrap modulo 256: a push at 8'h00 leaves 8'hFF, and a pull at 8'hFF reads address 16'h0100 and leaves 8'h00.
- R4: A call pushes `pcIn + 2`, high byte first and then low byte, and loads `callTarget` into `pcOut`.
- R5: A return pulls the low byte and then the high byte, and loads that address plus one into `pcOut`.
- R6: A break pushes `pcIn + 2` (high byte, then low byte) and then `statusIn` with bit 4 set. It then reads 16'hFFFE (low byte) and 16'hFFFF (high byte) into `pcOut`, and sets `statusOut` to `statusIn` with bits 4 and 2 set. It runs even when bit 2 of `statusIn` is already set.
- R7: A return from interrupt pulls the flags, then the low byte, then the high byte. It loads the flags into `statusOut` and the address into `pcOut` with no increment.
- R8: Pushing the accumulator or the flags writes one byte (`accIn` or `statusIn`). No result output changes.
- R9: Pulling the flags loads the pulled byte into `statusOut`. Pulling the accumulator loads the pulled byte into `accOut` and sets `statusOut` to `statusIn`, except that bit 7 is copied from bit 7 of the byte and bit 1 is set only when the byte is zero.
- R10: When several start strobes are high in the same idle cycle, exactly one operation runs. The winner is chosen in this order, highest first: break, return from interrupt, call, return, push flags, push accumulator, pull flags, pull accumulator.
- R11: A start strobe that arrives while `busy` is high is ignored.
- R12: `done` is a one-cycle pulse. It is high in the cycle that follows the edge at which the start is sampled by (memory steps + 2) cycles. The step counts are: call 2, return 2, break 5, return from interrupt 3, each single-byte operation 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBrk | input | 1 | Start a software break |
| startRti | input | 1 | Start a return from interrupt |
| startCall | input | 1 | Start a subroutine call |
| startRet | input | 1 | Start a subroutine return |
| startPushP | input | 1 | Start a push of the flags |
| startPushA | input | 1 | Start a push of the accumulator |
| startPullP | input | 1 | Start a pull of the flags |
| startPullA | input | 1 | Start a pull of the accumulator |
| pcIn | input | 16 | Program counter of the current instruction |
| statusIn | input | 8 | Current flag register |
| accIn | input | 8 | Current accumulator |
| callTarget | input | 16 | Destination address of a call |
| memRdata | input | 8 | Combinational read data |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable |
| pcOut | output | 16 | Resulting program counter |
| statusOut | output | 8 | Resulting flag register |
| accOut | output | 8 | Resulting accumulator |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two kinds of collision can occur in a single cycle: several start strobes high together, and a new start strobe arriving while a sequence is still running. The bench raises a call, an accumulator push and an accumulator pull in the same idle cycle. It then judges the outcome by the latency, the pointer movement, the loaded program counter and the bytes left in the stack page, which must all match the call alone. In a second test it pulses a flag pull one cycle after an accumulator push has been accepted. It then confirms that only one `done` pulse appears, that the pointer moved by exactly one, and that `statusOut` is unchanged.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Enum order is the start priority: a lower value wins.
  typedef enum logic [2:0] {
    OP_BRK  = 3'd0,
    OP_RTI  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_PHP  = 3'd4,
    OP_PHA  = 3'd5,
    OP_PLP  = 3'd6,
    OP_PLA  = 3'd7
  } opKind_t;

  typedef enum logic [2:0] {
    SRC_PCHI  = 3'd0,
    SRC_PCLO  = 3'd1,
    SRC_STATB = 3'd2,
    SRC_STAT  = 3'd3,
    SRC_ACC   = 3'd4
  } pushSrc_t;

  typedef enum logic [1:0] {
    DST_LO   = 2'd0,
    DST_HI   = 2'd1,
    DST_STAT = 2'd2
  } pullDst_t;

  typedef struct packed {
    logic     capture;
    logic     doPush;
    pushSrc_t src;
    logic     doPull;
    logic     doVec;
    logic     vecHi;
    pullDst_t dst;
    logic     commit;
    opKind_t  op;
  } strobe_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int N_OPS  = 8,
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_OPS-1:0] startVec,
  output strobe_t          stb,
  output logic             busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;

  state_t            state;
  opKind_t           curOp;
  logic [STEP_W-1:0] stepIdx;
  opKind_t           pickOp;
  logic              pickValid;
  logic              lastStep;
  logic              anyStart;

  assign anyStart  = |startVec;
  assign pickValid = (state == ST_IDLE) && anyStart;

  // Lowest set index wins.
  always_comb begin
    pickOp = OP_PLA;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (startVec[i]) pickOp = opKind_t'(3'(i));
    end
  end

  // Step table per operation.
  always_comb begin
    stb         = '0;
    stb.op      = curOp;
    stb.src     = SRC_PCHI;
    stb.dst     = DST_LO;
    stb.capture = pickValid;
    stb.commit  = (state == ST_FIN);
    lastStep    = 1'b0;
    if (state == ST_RUN) begin
      unique case (curOp)
        OP_BRK: begin
          unique case (stepIdx)
            3'd0:    begin stb.doPush = 1'b1; stb.src = SRC_PCHI;  end
            3'd1:    begin stb.doPush = 1'b1; stb.src = SRC_PCLO;  end
            3'd2:    begin stb.doPush = 1'b1; stb.src = SRC_STATB; end
            3'd3:    begin stb.doVec  = 1'b1; stb.dst = DST_LO;    end
            default: begin stb.doVec  = 1'b1; stb.vecHi = 1'b1; stb.dst = DST_HI; lastStep = 1'b1; end
          endcase
        end
        OP_RTI: begin
          stb.doPull = 1'b1;
          unique case (stepIdx)
            3'd0:    stb.dst = DST_STAT;
            3'd1:    stb.dst = DST_LO;
            default: begin stb.dst = DST_HI; lastStep = 1'b1; end
          endcase
        end
        OP_CALL: begin
          stb.doPush = 1'b1;
          if (stepIdx == 3'd0) stb.src = SRC_PCHI;
          else begin stb.src = SRC_PCLO; lastStep = 1'b1; end
        end
        OP_RET: begin
          stb.doPull = 1'b1;
          if (stepIdx == 3'd0) stb.dst = DST_LO;
          else begin stb.dst = DST_HI; lastStep = 1'b1; end
        end
        OP_PHP: begin stb.doPush = 1'b1; stb.src = SRC_STAT; lastStep = 1'b1; end
        OP_PHA: begin stb.doPush = 1'b1; stb.src = SRC_ACC;  lastStep = 1'b1; end
        OP_PLP: begin stb.doPull = 1'b1; stb.dst = DST_STAT; lastStep = 1'b1; end
        default: begin stb.doPull = 1'b1; stb.dst = DST_LO;  lastStep = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curOp   <= OP_BRK;
      stepIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (pickValid) begin
          state   <= ST_RUN;
          curOp   <= pickOp;
          stepIdx <= '0;
        end
        ST_RUN: begin
          if (lastStep) state <= ST_FIN;
          stepIdx <= stepIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R11: a start seen while busy must not change the running operation.
  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyStart) |=> $stable(curOp));

  // R10: break outranks every other start.
  a_r10_break_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startVec[0]) |=> (curOp == OP_BRK));

  // R12: the commit cycle is never back to back.
  a_r12_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.commit);

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] RESET_SP   = 8'hFF,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE,
  parameter int              BRK_BIT    = 4,
  parameter int              IMASK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [ADDR_W-1:0] callTarget,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] sp,
  output logic              done
);

  localparam int N_BIT = DATA_W - 1;
  localparam int Z_BIT = 1;
  localparam logic [DATA_W-1:0] BRK_MASK = DATA_W'(1) << BRK_BIT;
  localparam logic [DATA_W-1:0] IRQ_MASK = DATA_W'(1) << IMASK_BIT;

  logic [ADDR_W-1:0] retAddr, target;
  logic [DATA_W-1:0] statLatch, accLatch;
  logic [DATA_W-1:0] tmpLo, tmpHi, tmpStat;
  logic [DATA_W-1:0] spInc;
  logic [DATA_W-1:0] nzStatus;

  assign spInc = sp + 1'b1;

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memWe    = 1'b0;
    memRe    = 1'b0;
    if (stb.doPush) begin
      memAddr = {STACK_PAGE, sp};
      memWe   = 1'b1;
      unique case (stb.src)
        SRC_PCHI:  memWdata = retAddr[ADDR_W-1:DATA_W];
        SRC_PCLO:  memWdata = retAddr[DATA_W-1:0];
        SRC_STATB: memWdata = statLatch | BRK_MASK;
        SRC_STAT:  memWdata = statLatch;
        default:   memWdata = accLatch;
      endcase
    end else if (stb.doPull) begin
      memAddr = {STACK_PAGE, spInc};
      memRe   = 1'b1;
    end else if (stb.doVec) begin
      memAddr = VEC_ADDR | ADDR_W'(stb.vecHi);
      memRe   = 1'b1;
    end
  end

  always_comb begin
    nzStatus        = statLatch;
    nzStatus[N_BIT] = tmpLo[N_BIT];
    nzStatus[Z_BIT] = (tmpLo == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp        <= RESET_SP;
      retAddr   <= '0;
      target    <= '0;
      statLatch <= '0;
      accLatch  <= '0;
      tmpLo     <= '0;
      tmpHi     <= '0;
      tmpStat   <= '0;
      pcOut     <= '0;
      statusOut <= '0;
      accOut    <= '0;
      done      <= 1'b0;
    end else begin
      done <= stb.commit;
      if (stb.capture) begin
        retAddr   <= pcIn + ADDR_W'(2);
        target    <= callTarget;
        statLatch <= statusIn;
        accLatch  <= accIn;
      end
      if (stb.doPush) sp <= sp - 1'b1;
      if (stb.doPull) sp <= spInc;
      if (stb.doPull || stb.doVec) begin
        unique case (stb.dst)
          DST_LO:  tmpLo   <= memRdata;
          DST_HI:  tmpHi   <= memRdata;
          default: tmpStat <= memRdata;
        endcase
      end
      if (stb.commit) begin
        unique case (stb.op)
          OP_BRK: begin
            pcOut     <= {tmpHi, tmpLo};
            statusOut <= statLatch | BRK_MASK | IRQ_MASK;
          end
          OP_RTI: begin
            pcOut     <= {tmpHi, tmpLo};
            statusOut <= tmpStat;
          end
          OP_CALL: pcOut <= target;
          OP_RET:  pcOut <= {tmpHi, tmpLo} + 1'b1;
          OP_PLP:  statusOut <= tmpStat;
          OP_PLA: begin
            accOut    <= tmpLo;
            statusOut <= nzStatus;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: writes always land in the stack page.
  a_r2_write_in_page: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ADDR_W-1:DATA_W] == STACK_PAGE));

  // R3: a push leaves the pointer one below its value at the write.
  a_r3_push_decrements: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (sp == $past(sp) - 1'b1));

  // R3: after a stack read the pointer names the byte just read.
  a_r3_pull_points_read: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && memAddr[ADDR_W-1:DATA_W] == STACK_PAGE) |=> (sp == $past(memAddr[DATA_W-1:0])));

  // R6: any read outside the stack page is a vector byte.
  a_r6_vector_only: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && memAddr[ADDR_W-1:DATA_W] != STACK_PAGE) |-> (memAddr[ADDR_W-1:1] == VEC_ADDR[ADDR_W-1:1]));

  // R12: done never lasts two cycles.
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBrk,
  input  logic              startRti,
  input  logic              startCall,
  input  logic              startRet,
  input  logic              startPushP,
  input  logic              startPushA,
  input  logic              startPullP,
  input  logic              startPullA,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [ADDR_W-1:0] callTarget,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              done
);

  localparam int N_OPS = 8;

  logic [N_OPS-1:0] startVec;
  strobe_t          stb;

  // Bit index equals the opKind_t value, so the index is the priority.
  assign startVec = {startPullA, startPullP, startPushA, startPushP,
                     startRet, startCall, startRti, startBrk};

  stk_ctrl #(.N_OPS(N_OPS), .STEP_W(3)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startVec (startVec),
    .stb      (stb),
    .busy     (busy)
  );

  stk_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .pcIn       (pcIn),
    .statusIn   (statusIn),
    .accIn      (accIn),
    .callTarget (callTarget),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memWe      (memWe),
    .memRe      (memRe),
    .pcOut      (pcOut),
    .statusOut  (statusOut),
    .accOut     (accOut),
    .sp         (sp),
    .done       (done)
  );

endmodule

// File: tb/stack_seq_tb.sv
module stack_seq_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  startBits;
  logic [15:0] pcIn, callTarget, memAddr, pcOut;
  logic [7:0]  statusIn, accIn, memRdata, memWdata, statusOut, accOut, sp;
  logic        memWe, memRe, busy, done;

  int total = 0;
  int fails = 0;

  localparam logic [7:0] VEC_LO = 8'h34;
  localparam logic [7:0] VEC_HI = 8'hE0;

  always #4 clk = ~clk;

  stack_seq u_dut (
    .clk(clk), .rstN(rstN),
    .startBrk(startBits[0]), .startRti(startBits[1]), .startCall(startBits[2]),
    .startRet(startBits[3]), .startPushP(startBits[4]), .startPushA(startBits[5]),
    .startPullP(startBits[6]), .startPullA(startBits[7]),
    .pcIn(pcIn), .statusIn(statusIn), .accIn(accIn), .callTarget(callTarget),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .pcOut(pcOut), .statusOut(statusOut),
    .accOut(accOut), .sp(sp), .busy(busy), .done(done)
  );

  // Memory model: stack page plus two vector bytes.
  logic [7:0] stackMem [256];
  initial for (int i = 0; i < 256; i++) stackMem[i] = 8'h00;
  always_ff @(posedge clk) if (memWe && memAddr[15:8] == 8'h01) stackMem[memAddr[7:0]] <= memWdata;
  always_comb begin
    if (memAddr[15:8] == 8'h01) memRdata = stackMem[memAddr[7:0]];
    else if (memAddr == 16'hFFFE) memRdata = VEC_LO;
    else if (memAddr == 16'hFFFF) memRdata = VEC_HI;
    else memRdata = 8'h00;
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Start bit index: 0 brk, 1 rti, 2 call, 3 ret, 4 push flags, 5 push acc, 6 pull flags, 7 pull acc.
  task automatic runOp(input logic [7:0] bits, input logic [15:0] pc, input logic [7:0] st,
                       input logic [7:0] acc, input logic [15:0] tgt, output int lat);
    @(negedge clk);
    startBits = bits; pcIn = pc; statusIn = st; accIn = acc; callTarget = tgt;
    @(negedge clk);
    startBits = '0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  typedef struct packed {
    logic [7:0]  bits;
    logic [15:0] pc;
    logic [7:0]  st;
    logic [7:0]  acc;
    logic [15:0] tgt;
    logic [2:0]  mask;
    logic [15:0] ePc;
    logic [7:0]  eSt;
    logic [7:0]  eAcc;
    logic [7:0]  eSp;
    logic [7:0]  eLat;
  } vec_t;

  // mask: bit0 pc, bit1 status, bit2 acc. Chained: each row starts where the last left the stack.
  localparam vec_t TABLE [11] = '{
    '{8'h04, 16'h1234, 8'h00, 8'h00, 16'h8000, 3'b001, 16'h8000, 8'h00, 8'h00, 8'hFD, 8'd4}, // R4 call
    '{8'h20, 16'h0000, 8'h00, 8'h5A, 16'h0000, 3'b000, 16'h0000, 8'h00, 8'h00, 8'hFC, 8'd3}, // R8 push acc
    '{8'h10, 16'h0000, 8'hC3, 8'h00, 16'h0000, 3'b000, 16'h0000, 8'h00, 8'h00, 8'hFB, 8'd3}, // R8 push flags
    '{8'h80, 16'h0000, 8'h4D, 8'h00, 16'h0000, 3'b110, 16'h0000, 8'hCD, 8'hC3, 8'hFC, 8'd3}, // R9 pull acc N
    '{8'h40, 16'h0000, 8'h00, 8'h00, 16'h0000, 3'b010, 16'h0000, 8'h5A, 8'h00, 8'hFD, 8'd3}, // R9 pull flags
    '{8'h08, 16'h0000, 8'h00, 8'h00, 16'h0000, 3'b001, 16'h1237, 8'h00, 8'h00, 8'hFF, 8'd4}, // R5 return +1
    '{8'h01, 16'h2000, 8'h00, 8'h00, 16'h0000, 3'b011, 16'hE034, 8'h14, 8'h00, 8'hFC, 8'd7}, // R6 break
    '{8'h02, 16'h0000, 8'h00, 8'h00, 16'h0000, 3'b011, 16'h2002, 8'h10, 8'h00, 8'hFF, 8'd5}, // R7 rti
    '{8'h80, 16'h0000, 8'hFF, 8'h00, 16'h0000, 3'b110, 16'h0000, 8'h7F, 8'h00, 8'h00, 8'd3}, // R3 pull wrap, R9 Z
    '{8'h20, 16'h0000, 8'h00, 8'h77, 16'h0000, 3'b000, 16'h0000, 8'h00, 8'h00, 8'hFF, 8'd3}, // R3 push wrap
    '{8'h80, 16'h0000, 8'h00, 8'h00, 16'h0000, 3'b110, 16'h0000, 8'h00, 8'h77, 8'h00, 8'd3}  // R3 wrapped byte
  };

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL R12 watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lat;
    int extraDone;
    startBits = '0; pcIn = '0; statusIn = '0; accIn = '0; callTarget = '0;
    doReset();
    // R1 reset state
    chk("R1", "sp", {8'h00, sp}, 16'h00FF);
    chk("R1", "done", {15'h0, done}, 16'h0);
    chk("R1", "busy", {15'h0, busy}, 16'h0);

    for (int k = 0; k < 11; k++) begin
      runOp(TABLE[k].bits, TABLE[k].pc, TABLE[k].st, TABLE[k].acc, TABLE[k].tgt, lat);
      chk("R12", "latency", 16'(lat), {8'h00, TABLE[k].eLat});
      chk("R3", "sp", {8'h00, sp}, {8'h00, TABLE[k].eSp});
      if (TABLE[k].mask[0]) chk("R4/R5/R6/R7", "pcOut", pcOut, TABLE[k].ePc);
      if (TABLE[k].mask[1]) chk("R6/R7/R9", "statusOut", {8'h00, statusOut}, {8'h00, TABLE[k].eSt});
      if (TABLE[k].mask[2]) chk("R9", "accOut", {8'h00, accOut}, {8'h00, TABLE[k].eAcc});
      if (k == 0) begin
        chk("R4", "pushed high", {8'h00, stackMem[8'hFF]}, 16'h0012);
        chk("R4", "pushed low", {8'h00, stackMem[8'hFE]}, 16'h0036);
      end
      if (k == 6) chk("R6", "pushed flags", {8'h00, stackMem[8'hFD]}, 16'h0010);
      if (k == 9) chk("R3", "wrap write", {8'h00, stackMem[8'h00]}, 16'h0077);
      @(negedge clk);
      chk("R12", "done drops", {15'h0, done}, 16'h0);
    end

    // Directed: call with carry into the high byte.
    doReset();
    runOp(8'h04, 16'h4FFE, 8'h00, 8'h00, 16'hABCD, lat);
    chk("R4", "carry high", {8'h00, stackMem[8'hFF]}, 16'h0050);
    chk("R4", "carry low", {8'h00, stackMem[8'hFE]}, 16'h0000);
    chk("R4", "target", pcOut, 16'hABCD);

    // Directed: break with the interrupt mask already set.
    runOp(8'h01, 16'h10FF, 8'h04, 8'h00, 16'h0000, lat);
    chk("R6", "masked brk latency", 16'(lat), 16'd7);
    chk("R6", "masked brk pc", pcOut, 16'hE034);
    chk("R6", "masked brk status", {8'h00, statusOut}, 16'h0014);
    chk("R6", "masked brk pushed", {8'h00, stackMem[8'hFB]}, 16'h0014);
    chk("R6", "masked brk ret lo", {8'h00, stackMem[8'hFC]}, 16'h0001);

    // Directed: three strobes together; the call must win.
    runOp(8'hA4, 16'h0300, 8'h00, 8'h99, 16'h9000, lat);
    chk("R10", "collision latency", 16'(lat), 16'd4);
    chk("R10", "collision pc", pcOut, 16'h9000);
    chk("R10", "collision sp", {8'h00, sp}, 16'h00F8);
    chk("R10", "collision hi", {8'h00, stackMem[8'hFA]}, 16'h0003);
    chk("R10", "collision lo", {8'h00, stackMem[8'hF9]}, 16'h0002);
    chk("R10", "collision acc", {8'h00, accOut}, 16'h0000);

    // Directed: a flag pull arriving while busy must be dropped.
    @(negedge clk);
    startBits = 8'h20; accIn = 8'hA5;
    @(negedge clk);
    startBits = 8'h40;
    @(negedge clk);
    startBits = 8'h00;
    lat = 2;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk("R11", "busy latency", 16'(lat), 16'd3);
    extraDone = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (done) extraDone++;
    end
    chk("R11", "extra done", 16'(extraDone), 16'd0);
    chk("R11", "sp after ignore", {8'h00, sp}, 16'h00F7);
    chk("R11", "status kept", {8'h00, statusOut}, 16'h0014);
    chk("R8", "acc pushed", {8'h00, stackMem[8'hF8]}, 16'h00A5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule